// File: doc/BRIEF.md
# Debug Event Router with Sticky Status

This block sits beside a processor core's debug comparators and counters. Each cycle it takes one-cycle event pulses from fourteen debug sources. The sources are a trap, four instruction-address compares, two data-address compares (each with a read/write qualifier and a 2-bit mode field), a return, two external events, two debug counters, a critical interrupt and a critical return. The block records every qualified event as a sticky bit in a 32-bit status word. Software clears a bit by writing a 1 to its position.

The block also decides who handles each event. A per-source ownership register is loaded only from the debug port. When external debug mode is on, a source whose ownership bit is 1 belongs to the hardware debugger, and its events request debug-mode entry. Every other event is handled as in internal debug mode: it requests a debug interrupt when both the internal-debug-mode enable and the machine-state debug enable are 1. When external debug mode is off, the ownership register has no effect.

Both requests are formed from the current cycle's events and leave the block through one register stage. A small offset field and an imprecise flag record how the most recent data-address compare was reported.

Top module: `dbg_evt_router`

## Requirements
- R1: With `edm`=0 every event is software-owned whatever `own_q` holds: `halt_req` stays 0, and `dbg_irq` follows the R4 rule.
- R2: With `edm`=1, an event from a source whose `own_q` bit is 1 sets `halt_req` in the following cycle and does not by itself raise `dbg_irq`. Source index order is: 0 trap, 1..4 instruction compares 1..4, 5..6 data compares 1..2, 7 return, 8..9 external events 1..2, 10..11 counters 1..2, 12 critical interrupt, 13 critical return.
- R3: With `edm`=1, an event from a source whose `own_q` bit is 0 raises `dbg_irq` exactly as in R4, and it can do so in the same cycle as a hardware-owned event raises `halt_req`.
- R4: A software-handled event raises `dbg_irq` only when `idm`=1 and `msr_de`=1.
- R5: `own_q` changes only in the cycle after `own_we`=1, when it takes `own_wdata`. Status clears never change it.
- R6: For data compare k, bits `dac_mode[2k+1:2k]` set the mode. The read status bit is set on a read match (`dac_wr[k]`=0) only when the mode is 2'b10 or 2'b11. The write status bit is set on a write match only when the mode is 2'b01 or 2'b11. A match that the mode blocks is not an event.
- R7: Status bit numbering takes 32 as the most significant bit, and bit b sits at port index 63-b. The positions are: trap 39; instruction compares 1..4 at 40..43; data compare 1 read/write at 44/45 and data compare 2 read/write at 46/47; return 48; external events 1..2 at 53..54; counters 1..2 at 55..56; critical interrupt 57; critical return 58; counter-1 triggered 63.
- R8: Status bits are sticky. A cycle with `clr_en`=1 clears exactly the positions where `clr_data` is 1. Zeros in `clr_data` leave bits unchanged.
- R9: When an event sets a bit in the same cycle as a clear targets it, the bit ends up set.
- R10: Bits 33..38, 49..52 and 59..60 (index 30..25, 14..11, 4..3) always read 0.
- R11: Each qualified data-compare event loads the offset field at bits 61..62 (index 2:1). The field takes 2'b01 when `dac_dvc`=1 and 2'b00 otherwise. When `dac_xlat_err`=1 the field is forced to 2'b00 and the sticky imprecise flag at bit 32 (index 31) is set.
- R12: A pulse on `cnt1_trg` sets bit 63 (index 0) and raises neither request.
- R13: After reset, `status`, `own_q`, `halt_req` and `dbg_irq` are 0. Each request is a one-cycle pulse for a one-cycle event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| edm | input | 1 | External debug mode enable |
| idm | input | 1 | Internal debug mode enable |
| msr_de | input | 1 | Machine-state debug enable |
| own_we | input | 1 | Debug-port write strobe for the ownership register |
| own_wdata | input | 14 | Ownership value, 1 = hardware-owned |
| own_q | output | 14 | Ownership register contents |
| evt_trap | input | 1 | Trap event pulse |
| evt_iac | input | 4 | Instruction compare event pulses |
| evt_dac | input | 2 | Data compare match pulses |
| dac_wr | input | 2 | Match type, 1 = write |
| dac_mode | input | 4 | Per-unit 2-bit mode fields |
| dac_dvc | input | 1 | Match is value-qualified |
| dac_xlat_err | input | 1 | Translation/storage error with the match |
| evt_ret | input | 1 | Return event pulse |
| evt_ext | input | 2 | External event pulses |
| evt_cnt | input | 2 | Counter event pulses |
| evt_cint | input | 1 | Critical interrupt event pulse |
| evt_cret | input | 1 | Critical return event pulse |
| cnt1_trg | input | 1 | Counter 1 triggered pulse |
| clr_en | input | 1 | Software write-one-to-clear strobe |
| clr_data | input | 32 | Positions to clear |
| halt_req | output | 1 | Request to enter debug mode |
| dbg_irq | output | 1 | Debug interrupt request |
| status | output | 32 | Status word |

## Verification
The bound checker watches on every cycle that a halt request only follows a cycle with external debug mode on, that an interrupt request only follows a cycle with both enables on, and that reserved positions stay zero. It also checks that set bits never drop without a matching clear, that the ownership register moves only after a debug-port write, that each data-compare status bit rises only under a mode that permits it, and that the imprecise flag comes with a zero offset. Only the directed scenarios show the positive side. That covers the exact bit position each source lands on, the split between halt and interrupt under mixed ownership, the blocked data-compare modes, set-over-clear priority, the offset values for value-qualified matches, and that a one-cycle event gives a one-cycle request.

// File: rtl/dbg_evt_pkg.sv
package dbg_evt_pkg;
   // Status word layout; port index = 63 - (bit number counted from 32 as MSB)
   localparam int POS_IMPR   = 31;
   localparam int POS_TRAP   = 24;
   localparam int POS_IAC1   = 23;
   localparam int POS_DAC1R  = 19;
   localparam int POS_RET    = 15;
   localparam int POS_EXT1   = 10;
   localparam int POS_CNT1   = 8;
   localparam int POS_CINT   = 6;
   localparam int POS_CRET   = 5;
   localparam int POS_OFS_HI = 2;
   localparam int POS_OFS_LO = 1;
   localparam int POS_TRG    = 0;

   localparam logic [31:0] SR_VALID = 32'h81FF_87E7;
   localparam logic [31:0] SR_OFS   = 32'h0000_0006;

   localparam logic [1:0] OFS_PLAIN = 2'b00;
   localparam logic [1:0] OFS_DVC   = 2'b01;
endpackage

// File: rtl/dbg_evt_qualify.sv
module dbg_evt_qualify #(
   parameter int N_IAC = 4,
   parameter int N_DAC = 2,
   parameter int N_EXT = 2,
   parameter int N_CNT = 2,
   parameter int N_SRC = 14
) (
   input  logic               evt_trap,
   input  logic [N_IAC-1:0]   evt_iac,
   input  logic [N_DAC-1:0]   evt_dac,
   input  logic [N_DAC-1:0]   dac_wr,
   input  logic [2*N_DAC-1:0] dac_mode,
   input  logic               evt_ret,
   input  logic [N_EXT-1:0]   evt_ext,
   input  logic [N_CNT-1:0]   evt_cnt,
   input  logic               evt_cint,
   input  logic               evt_cret,
   output logic [N_DAC-1:0]   dac_rd_hit,
   output logic [N_DAC-1:0]   dac_wr_hit,
   output logic [N_SRC-1:0]   src_hit
);
   logic [N_DAC-1:0] dac_any;

   for (genvar k = 0; k < N_DAC; k++) begin : g_dac
      // mode bit 1 enables reads, mode bit 0 enables writes
      assign dac_rd_hit[k] = evt_dac[k] & ~dac_wr[k] & dac_mode[2*k+1];
      assign dac_wr_hit[k] = evt_dac[k] &  dac_wr[k] & dac_mode[2*k];
      assign dac_any[k]    = dac_rd_hit[k] | dac_wr_hit[k];
   end

   assign src_hit = {evt_cret, evt_cint, evt_cnt, evt_ext, evt_ret,
                     dac_any, evt_iac, evt_trap};
endmodule

// File: rtl/dbg_evt_route.sv
module dbg_evt_route #(
   parameter int N_SRC = 14
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             edm,
   input  logic             idm,
   input  logic             msr_de,
   input  logic             own_we,
   input  logic [N_SRC-1:0] own_wdata,
   input  logic [N_SRC-1:0] src_hit,
   output logic [N_SRC-1:0] own_q,
   output logic             halt_d,
   output logic             irq_d
);
   logic [N_SRC-1:0] hw_sel;
   logic [N_SRC-1:0] sw_sel;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      own_q <= '0;
      else if (own_we) own_q <= own_wdata;
   end

   assign hw_sel = src_hit & own_q & {N_SRC{edm}};
   assign sw_sel = src_hit & ~hw_sel;
   assign halt_d = |hw_sel;
   assign irq_d  = (|sw_sel) & idm & msr_de;
endmodule

// File: rtl/dbg_evt_status.sv
module dbg_evt_status
   import dbg_evt_pkg::*;
#(
   parameter int N_IAC = 4,
   parameter int N_DAC = 2,
   parameter int N_EXT = 2,
   parameter int N_CNT = 2,
   parameter int SR_W  = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             evt_trap,
   input  logic [N_IAC-1:0] evt_iac,
   input  logic [N_DAC-1:0] dac_rd_hit,
   input  logic [N_DAC-1:0] dac_wr_hit,
   input  logic             evt_ret,
   input  logic [N_EXT-1:0] evt_ext,
   input  logic [N_CNT-1:0] evt_cnt,
   input  logic             evt_cint,
   input  logic             evt_cret,
   input  logic             cnt1_trg,
   input  logic             dac_dvc,
   input  logic             dac_xlat_err,
   input  logic             clr_en,
   input  logic [SR_W-1:0]  clr_data,
   output logic [SR_W-1:0]  status
);
   logic [SR_W-1:0] set_v;
   logic [SR_W-1:0] clr_v;
   logic [SR_W-1:0] nxt;
   logic            dac_evt;
   logic [1:0]      ofs_new;

   assign dac_evt = |(dac_rd_hit | dac_wr_hit);
   assign ofs_new = dac_xlat_err ? OFS_PLAIN : (dac_dvc ? OFS_DVC : OFS_PLAIN);
   assign clr_v   = clr_en ? clr_data : '0;

   always_comb begin
      set_v           = '0;
      set_v[POS_TRAP] = evt_trap;
      for (int k = 0; k < N_IAC; k++) set_v[POS_IAC1-k] = evt_iac[k];
      for (int k = 0; k < N_DAC; k++) begin
         set_v[POS_DAC1R-2*k]   = dac_rd_hit[k];
         set_v[POS_DAC1R-2*k-1] = dac_wr_hit[k];
      end
      set_v[POS_RET]  = evt_ret;
      for (int k = 0; k < N_EXT; k++) set_v[POS_EXT1-k] = evt_ext[k];
      for (int k = 0; k < N_CNT; k++) set_v[POS_CNT1-k] = evt_cnt[k];
      set_v[POS_CINT] = evt_cint;
      set_v[POS_CRET] = evt_cret;
      set_v[POS_TRG]  = cnt1_trg;
      set_v[POS_IMPR] = dac_evt & dac_xlat_err;
   end

   always_comb begin
      // set wins over clear on the same bit
      nxt = (status & ~clr_v) | set_v;
      if (dac_evt) nxt[POS_OFS_HI:POS_OFS_LO] = ofs_new;
      nxt = nxt & SR_VALID;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) status <= '0;
      else        status <= nxt;
   end
endmodule

// File: rtl/dbg_evt_router.sv
module dbg_evt_router
   import dbg_evt_pkg::*;
#(
   parameter int N_IAC   = 4,
   parameter int N_DAC   = 2,
   parameter int N_EXT   = 2,
   parameter int N_CNT   = 2,
   parameter int SR_W    = 32,
   parameter bit REG_OUT = 1'b1,
   localparam int N_SRC  = 6 + N_IAC + N_DAC + N_EXT + N_CNT - 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               edm,
   input  logic               idm,
   input  logic               msr_de,
   input  logic               own_we,
   input  logic [N_SRC-1:0]   own_wdata,
   output logic [N_SRC-1:0]   own_q,
   input  logic               evt_trap,
   input  logic [N_IAC-1:0]   evt_iac,
   input  logic [N_DAC-1:0]   evt_dac,
   input  logic [N_DAC-1:0]   dac_wr,
   input  logic [2*N_DAC-1:0] dac_mode,
   input  logic               dac_dvc,
   input  logic               dac_xlat_err,
   input  logic               evt_ret,
   input  logic [N_EXT-1:0]   evt_ext,
   input  logic [N_CNT-1:0]   evt_cnt,
   input  logic               evt_cint,
   input  logic               evt_cret,
   input  logic               cnt1_trg,
   input  logic               clr_en,
   input  logic [SR_W-1:0]    clr_data,
   output logic               halt_req,
   output logic               dbg_irq,
   output logic [SR_W-1:0]    status
);
   if (SR_W != 32) begin : g_bad_width
      $error("dbg_evt_router: status layout needs SR_W == 32");
   end
   if (N_IAC != 4 || N_DAC != 2 || N_EXT != 2 || N_CNT != 2) begin : g_bad_count
      $error("dbg_evt_router: source counts must match the status layout");
   end

   logic [N_DAC-1:0] dac_rd_hit;
   logic [N_DAC-1:0] dac_wr_hit;
   logic [N_SRC-1:0] src_hit;
   logic             halt_d;
   logic             irq_d;

   dbg_evt_qualify #(
      .N_IAC(N_IAC), .N_DAC(N_DAC), .N_EXT(N_EXT), .N_CNT(N_CNT), .N_SRC(N_SRC)
   ) u_qual (
      .evt_trap   (evt_trap),
      .evt_iac    (evt_iac),
      .evt_dac    (evt_dac),
      .dac_wr     (dac_wr),
      .dac_mode   (dac_mode),
      .evt_ret    (evt_ret),
      .evt_ext    (evt_ext),
      .evt_cnt    (evt_cnt),
      .evt_cint   (evt_cint),
      .evt_cret   (evt_cret),
      .dac_rd_hit (dac_rd_hit),
      .dac_wr_hit (dac_wr_hit),
      .src_hit    (src_hit)
   );

   dbg_evt_route #(.N_SRC(N_SRC)) u_route (
      .clk       (clk),
      .rst_n     (rst_n),
      .edm       (edm),
      .idm       (idm),
      .msr_de    (msr_de),
      .own_we    (own_we),
      .own_wdata (own_wdata),
      .src_hit   (src_hit),
      .own_q     (own_q),
      .halt_d    (halt_d),
      .irq_d     (irq_d)
   );

   dbg_evt_status #(
      .N_IAC(N_IAC), .N_DAC(N_DAC), .N_EXT(N_EXT), .N_CNT(N_CNT), .SR_W(SR_W)
   ) u_stat (
      .clk          (clk),
      .rst_n        (rst_n),
      .evt_trap     (evt_trap),
      .evt_iac      (evt_iac),
      .dac_rd_hit   (dac_rd_hit),
      .dac_wr_hit   (dac_wr_hit),
      .evt_ret      (evt_ret),
      .evt_ext      (evt_ext),
      .evt_cnt      (evt_cnt),
      .evt_cint     (evt_cint),
      .evt_cret     (evt_cret),
      .cnt1_trg     (cnt1_trg),
      .dac_dvc      (dac_dvc),
      .dac_xlat_err (dac_xlat_err),
      .clr_en       (clr_en),
      .clr_data     (clr_data),
      .status       (status)
   );

   if (REG_OUT) begin : g_reg_out
      logic halt_q;
      logic irq_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            halt_q <= 1'b0;
            irq_q  <= 1'b0;
         end else begin
            halt_q <= halt_d;
            irq_q  <= irq_d;
         end
      end
      assign halt_req = halt_q;
      assign dbg_irq  = irq_q;
   end else begin : g_comb_out
      assign halt_req = halt_d;
      assign dbg_irq  = irq_d;
   end
endmodule

// File: rtl/dbg_evt_router_chk.sv
module dbg_evt_router_chk
   import dbg_evt_pkg::*;
#(
   parameter int N_SRC   = 14,
   parameter int N_DAC   = 2,
   parameter int SR_W    = 32,
   parameter bit REG_OUT = 1'b1
) (
   input logic               clk,
   input logic               rst_n,
   input logic               edm,
   input logic               idm,
   input logic               msr_de,
   input logic               own_we,
   input logic [N_SRC-1:0]   own_q,
   input logic [2*N_DAC-1:0] dac_mode,
   input logic               clr_en,
   input logic [SR_W-1:0]    clr_data,
   input logic               halt_req,
   input logic               dbg_irq,
   input logic [SR_W-1:0]    status
);
   if (REG_OUT) begin : g_req
      AST_HALT_NEEDS_EDM: assert property (@(posedge clk) disable iff (!rst_n)
         halt_req |-> $past(edm)); // R2
      AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
         dbg_irq |-> ($past(idm) && $past(msr_de))); // R4
   end

   AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (status & ~SR_VALID) == '0); // R10

   AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (($past(status) & ~($past(clr_en) ? $past(clr_data) : '0) & ~status & ~SR_OFS) == '0)); // R8

   AST_OWN_PORT_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(own_we) |-> (own_q == $past(own_q))); // R5

   AST_IMPR_ZERO_OFS: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(status[POS_IMPR]) |-> (status[POS_OFS_HI:POS_OFS_LO] == 2'b00)); // R11

   for (genvar k = 0; k < N_DAC; k++) begin : g_dac
      AST_DAC_RD_MODE: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(status[POS_DAC1R-2*k]) |-> $past(dac_mode[2*k+1])); // R6
      AST_DAC_WR_MODE: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(status[POS_DAC1R-2*k-1]) |-> $past(dac_mode[2*k])); // R6
   end
endmodule

bind dbg_evt_router dbg_evt_router_chk #(
   .N_SRC(N_SRC), .N_DAC(N_DAC), .SR_W(SR_W), .REG_OUT(REG_OUT)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .edm      (edm),
   .idm      (idm),
   .msr_de   (msr_de),
   .own_we   (own_we),
   .own_q    (own_q),
   .dac_mode (dac_mode),
   .clr_en   (clr_en),
   .clr_data (clr_data),
   .halt_req (halt_req),
   .dbg_irq  (dbg_irq),
   .status   (status)
);

// File: tb/dbg_evt_router_bench.sv
`timescale 1ns/1ps
module dbg_evt_router_bench;
   localparam int NS = 14;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        edm = 1'b0, idm = 1'b0, msr_de = 1'b0;
   logic        own_we = 1'b0;
   logic [13:0] own_wdata = '0;
   logic [13:0] own_q;
   logic        evt_trap = 1'b0;
   logic [3:0]  evt_iac = '0;
   logic [1:0]  evt_dac = '0, dac_wr = '0;
   logic [3:0]  dac_mode = '0;
   logic        dac_dvc = 1'b0, dac_xlat_err = 1'b0;
   logic        evt_ret = 1'b0;
   logic [1:0]  evt_ext = '0, evt_cnt = '0;
   logic        evt_cint = 1'b0, evt_cret = 1'b0, cnt1_trg = 1'b0;
   logic        clr_en = 1'b0;
   logic [31:0] clr_data = '0;
   logic        halt_req, dbg_irq;
   logic [31:0] status;

   int n_tests = 0;
   int n_fail  = 0;

   always #4 clk = ~clk;

   dbg_evt_router u_dbg_evt_router (
      .clk(clk), .rst_n(rst_n), .edm(edm), .idm(idm), .msr_de(msr_de),
      .own_we(own_we), .own_wdata(own_wdata), .own_q(own_q),
      .evt_trap(evt_trap), .evt_iac(evt_iac), .evt_dac(evt_dac), .dac_wr(dac_wr),
      .dac_mode(dac_mode), .dac_dvc(dac_dvc), .dac_xlat_err(dac_xlat_err),
      .evt_ret(evt_ret), .evt_ext(evt_ext), .evt_cnt(evt_cnt),
      .evt_cint(evt_cint), .evt_cret(evt_cret), .cnt1_trg(cnt1_trg),
      .clr_en(clr_en), .clr_data(clr_data),
      .halt_req(halt_req), .dbg_irq(dbg_irq), .status(status)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   task automatic clr_all();
      clr_en = 1'b1; clr_data = '1; step();
      clr_en = 1'b0; clr_data = '0;
   endtask

   task automatic own_write(input logic [13:0] v);
      own_we = 1'b1; own_wdata = v; step();
      own_we = 1'b0;
   endtask

   task automatic t_reset();
      chk("R13 status", status, 32'h0);
      chk("R13 own_q", {18'h0, own_q}, 32'h0);
      chk("R13 halt", {31'h0, halt_req}, 32'h0);
      chk("R13 irq", {31'h0, dbg_irq}, 32'h0);
   endtask

   task automatic t_edm_off();
      own_write('1);
      edm = 1'b0; idm = 1'b1; msr_de = 1'b1;
      evt_trap = 1'b1; step();
      chk("R1 halt", {31'h0, halt_req}, 32'h0);
      chk("R1 irq", {31'h0, dbg_irq}, 32'h1);
      chk("R7 trap pos", status, 32'h1 << 24);
      evt_trap = 1'b0; step();
      chk("R13 irq pulse", {31'h0, dbg_irq}, 32'h0);
      clr_all();
   endtask

   task automatic t_hw_owned();
      edm = 1'b1; own_write(14'h0001);
      evt_trap = 1'b1; step();
      chk("R2 halt", {31'h0, halt_req}, 32'h1);
      chk("R2 irq", {31'h0, dbg_irq}, 32'h0);
      evt_trap = 1'b0; step();
      chk("R13 halt pulse", {31'h0, halt_req}, 32'h0);
      clr_all();
   endtask

   task automatic t_sw_owned();
      evt_iac = 4'b0001; step();
      chk("R3 halt", {31'h0, halt_req}, 32'h0);
      chk("R3 irq", {31'h0, dbg_irq}, 32'h1);
      chk("R7 iac1 pos", status, 32'h1 << 23);
      evt_trap = 1'b1; step();
      chk("R3 mixed", {30'h0, halt_req, dbg_irq}, 32'h3);
      evt_trap = 1'b0; evt_iac = '0; step();
      clr_all();
   endtask

   task automatic t_irq_gate();
      edm = 1'b0; idm = 1'b0; msr_de = 1'b1;
      evt_ret = 1'b1; step();
      chk("R4 idm off", {30'h0, halt_req, dbg_irq}, 32'h0);
      evt_ret = 1'b0; idm = 1'b1; msr_de = 1'b0;
      evt_cint = 1'b1; step();
      chk("R4 de off", {30'h0, halt_req, dbg_irq}, 32'h0);
      evt_cint = 1'b0; step();
      chk("R7 ret cint pos", status, (32'h1 << 15) | (32'h1 << 6));
      msr_de = 1'b1;
      clr_all();
   endtask

   task automatic t_own_port();
      own_write(14'h2A5A);
      chk("R5 own write", {18'h0, own_q}, 32'h2A5A);
      own_wdata = 14'h1111; step();
      chk("R5 no strobe", {18'h0, own_q}, 32'h2A5A);
      clr_all(); step();
      chk("R5 clear no effect", {18'h0, own_q}, 32'h2A5A);
      own_write('0);
   endtask

   task automatic t_dac();
      edm = 1'b0;
      dac_mode = 4'b0000; evt_dac = 2'b01;
      dac_wr = 2'b00; step();
      chk("R6 mode00 rd irq", {31'h0, dbg_irq}, 32'h0);
      dac_wr = 2'b01; step();
      evt_dac = '0; step();
      chk("R6 mode00", status, 32'h0);
      dac_mode = 4'b0010; evt_dac = 2'b01;
      dac_wr = 2'b00; step(); dac_wr = 2'b01; step();
      evt_dac = '0; step();
      chk("R6 mode10", status, 32'h1 << 19);
      clr_all();
      dac_mode = 4'b0001; evt_dac = 2'b01;
      dac_wr = 2'b00; step(); dac_wr = 2'b01; step();
      evt_dac = '0; step();
      chk("R6 mode01", status, 32'h1 << 18);
      clr_all();
      dac_mode = 4'b1100; evt_dac = 2'b10;
      dac_wr = 2'b00; step(); dac_wr = 2'b10; step();
      evt_dac = '0; dac_wr = '0; step();
      chk("R6 dac2 mode11", status, (32'h1 << 17) | (32'h1 << 16));
      clr_all();
   endtask

   task automatic t_w1c();
      evt_ext = 2'b11; step(); evt_ext = '0;
      chk("R7 ext pos", status, 32'h600);
      clr_en = 1'b1; clr_data = 32'h0; step();
      chk("R8 zero write", status, 32'h600);
      clr_data = 32'h1 << 10; step();
      clr_en = 1'b0; clr_data = '0;
      chk("R8 one clears", status, 32'h200);
      clr_all();
   endtask

   task automatic t_priority();
      evt_cnt = 2'b01; clr_en = 1'b1; clr_data = '1; step();
      evt_cnt = '0; clr_en = 1'b0; clr_data = '0;
      chk("R9 set wins", status, 32'h1 << 8);
      clr_all();
   endtask

   task automatic t_all();
      edm = 1'b0; dac_mode = 4'b1111;
      evt_trap = 1'b1; evt_iac = '1; evt_ret = 1'b1; evt_ext = '1; evt_cnt = '1;
      evt_cint = 1'b1; evt_cret = 1'b1; cnt1_trg = 1'b1;
      evt_dac = 2'b11; dac_wr = 2'b00; step();
      evt_trap = 1'b0; evt_iac = '0; evt_ret = 1'b0; evt_ext = '0; evt_cnt = '0;
      evt_cint = 1'b0; evt_cret = 1'b0; cnt1_trg = 1'b0;
      dac_wr = 2'b11; dac_dvc = 1'b1; step();
      evt_dac = '0; dac_wr = '0; dac_dvc = 1'b0; step();
      chk("R10 full word", status, 32'h01FF_87E3);
      clr_all();
      chk("R8 clear all", status, 32'h0);
   endtask

   task automatic t_offset();
      dac_mode = 4'b0011;
      evt_dac = 2'b01; dac_dvc = 1'b1; step();
      chk("R11 dvc offset", status, (32'h1 << 19) | 32'h2);
      dac_wr = 2'b01; dac_xlat_err = 1'b1; step();
      evt_dac = '0; dac_wr = '0; dac_dvc = 1'b0; dac_xlat_err = 1'b0;
      chk("R11 xlat err", status, 32'h800C_0000);
      clr_all();
   endtask

   task automatic t_cnt1trg();
      idm = 1'b1; msr_de = 1'b1;
      cnt1_trg = 1'b1; step(); cnt1_trg = 1'b0;
      chk("R12 trig bit", status, 32'h1);
      chk("R12 no request", {30'h0, halt_req, dbg_irq}, 32'h0);
      clr_all();
   endtask

   initial begin
      repeat (3) step();
      t_reset();
      rst_n = 1'b1; step();
      t_edm_off();
      t_hw_owned();
      t_sw_owned();
      t_irq_gate();
      t_own_port();
      t_dac();
      t_w1c();
      t_priority();
      t_all();
      t_offset();
      t_cnt1trg();
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule